// File: doc/BRIEF.md
# Serial Interrupt Frame Decoder

This block sits behind the serial interrupt line of a system interface and turns the data slots of each serial interrupt cycle into discrete interrupt lines. A separate cycle sequencer generates the start and stop frames and presents a slot-timing strobe to this block. The strobe carries a slot index and a phase code. In each slot's sample phase the block captures the level of the serial line. That level then appears on the matching open-drain output and stays there until the same slot comes round again.

There are 21 data slots. Slots 0 to 15 map to the sixteen ISA-style lines, and bit 2 of that group carries the system management interrupt. Slot 16 is a channel-check slot: it is timed like the others, but its value goes nowhere. Slots 17 to 20 map to the four PCI-style lines, INTA through INTD. A drive-mode pin sets the recovery behaviour after a low sample. With the pin high, the block actively drives the line high for the recovery clock. With the pin low, the block leaves the line released.

The strobe is a valid-only stream with no ready. The serial line cannot be stalled, so there is no back-pressure: every strobe beat is consumed in the cycle it is presented. All other pins are plain levels.

Top module: `sirq_frame_decoder`

## Requirements
- R1: While `rst_n` is low, every bit of `isa_pull` and `pci_pull` is 0 and `line_drive_high` is 0, whatever the strobe and line do.
- R2: For a valid strobe with phase code 0 (sample) and index k in 0..15, `isa_pull[k]` takes the inverse of `line_in` at that clock edge (1 means the output pulls low). Bit 2 serves as the system management interrupt.
- R3: For a valid sample strobe with index 17..20, `pci_pull[index-17]` takes the inverse of `line_in` at that edge. Bit 0 is INTA and bit 3 is INTD.
- R4: A valid sample strobe with index 16 (channel-check slot) changes no interrupt output.
- R5: Phase codes 1 (recovery), 2 (turnaround) and 3 (unused), and any strobe with `slot_vld` low, change no interrupt output.
- R6: When `line_in` is low at a valid in-range sample edge and `drive_hi` is high, `line_drive_high` is 1 for exactly the following clock, which is the recovery phase, and 0 again after it.
- R7: When `drive_hi` is low at the sample edge, `line_drive_high` stays 0 whatever the line level.
- R8: A valid strobe with index 21..31 changes no interrupt output and never raises `line_drive_high`.
- R9: An interrupt output keeps its value across the samples of all other slots until its own slot is sampled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial interrupt clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_vld | input | 1 | Strobe valid for this clock |
| slot_idx | input | 5 | Current data slot, 0..20 |
| slot_phase | input | 2 | 0 sample, 1 recovery, 2 turnaround |
| line_in | input | 1 | Received level of the serial line |
| drive_hi | input | 1 | Recovery mode: 1 drive high, 0 release |
| isa_pull | output | 16 | Open-drain enables for ISA-style lines (bit 2 = SMI) |
| pci_pull | output | 4 | Open-drain enables for INTA..INTD |
| line_drive_high | output | 1 | Enable of the high driver on the serial line |

## Verification
The hardest case to reach is a stray sample reaching an output outside its own slot's sample phase. That could come from the recovery or turnaround clocks, from the channel-check slot, or from an index past the last slot. The stimulus sweeps every slot with both line levels and both drive modes. During each recovery phase it drives the opposite line level and flips the mode pin, so a misplaced capture shows up at once on the outputs. It then pushes out-of-range indices, phase code 3 and invalid strobes with the line held low, and it runs pseudo-random 21-slot patterns to show that each output holds across other slots.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  typedef enum logic [1:0] {
    PH_SAMPLE  = 2'd0,
    PH_RECOVER = 2'd1,
    PH_TURN    = 2'd2,
    PH_SPARE   = 2'd3
  } sirq_phase_e;

endpackage

// File: rtl/sirq_slot_decode.sv
module sirq_slot_decode #(
  parameter int NUM_ISA = 16,
  parameter int NUM_PCI = 4,
  parameter int IDX_W   = 5
) (
  input  logic               slot_vld,
  input  logic [IDX_W-1:0]   slot_idx,
  input  logic [1:0]         slot_phase,
  output logic               sample_hit,
  output logic [NUM_ISA-1:0] isa_sel,
  output logic [NUM_PCI-1:0] pci_sel
);
  import sirq_pkg::*;

  localparam int NUM_SLOTS = NUM_ISA + 1 + NUM_PCI;
  localparam int PCI_BASE  = NUM_ISA + 1;

  logic in_range;
  logic is_sample;

  assign in_range   = slot_idx < IDX_W'(NUM_SLOTS);
  assign is_sample  = slot_vld && (slot_phase == PH_SAMPLE);
  assign sample_hit = is_sample && in_range;

  for (genvar i = 0; i < NUM_ISA; i++) begin : g_isa
    assign isa_sel[i] = is_sample && (slot_idx == IDX_W'(i));
  end

  for (genvar j = 0; j < NUM_PCI; j++) begin : g_pci
    assign pci_sel[j] = is_sample && (slot_idx == IDX_W'(PCI_BASE + j));
  end

endmodule

// File: rtl/sirq_irq_latch.sv
module sirq_irq_latch #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sel,
  input  logic         line_in,
  output logic [W-1:0] pull
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pull[i] <= 1'b0;
      else if (sel[i]) pull[i] <= ~line_in;
    end
  end

  p_one_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));

  p_hold_unselected_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == '0) |=> $stable(pull));

  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != '0) |=> ($countones(pull & $past(sel)) == ($past(line_in) ? 0 : 1)));

endmodule

// File: rtl/sirq_line_drive.sv
module sirq_line_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_hit,
  input  logic line_in,
  input  logic drive_hi,
  output logic line_drive_high
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_drive_high <= 1'b0;
    else        line_drive_high <= sample_hit && !line_in && drive_hi;
  end

  p_drive_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    line_drive_high |-> $past(sample_hit && !line_in));

  p_mode_low_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    line_drive_high |-> $past(drive_hi));

  p_drive_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (line_drive_high && !sample_hit) |=> !line_drive_high);

endmodule

// File: rtl/sirq_frame_decoder.sv
module sirq_frame_decoder #(
  parameter int NUM_ISA = 16,
  parameter int NUM_PCI = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               slot_vld,
  input  logic [4:0]         slot_idx,
  input  logic [1:0]         slot_phase,
  input  logic               line_in,
  input  logic               drive_hi,
  output logic [NUM_ISA-1:0] isa_pull,
  output logic [NUM_PCI-1:0] pci_pull,
  output logic               line_drive_high
);

  localparam int NUM_SLOTS = NUM_ISA + 1 + NUM_PCI;
  localparam int IDX_W     = 5;
  localparam int CHK_SLOT  = NUM_ISA;

  logic               sample_hit;
  logic [NUM_ISA-1:0] isa_sel;
  logic [NUM_PCI-1:0] pci_sel;

  sirq_slot_decode #(
    .NUM_ISA (NUM_ISA),
    .NUM_PCI (NUM_PCI),
    .IDX_W   (IDX_W)
  ) u_decode (
    .slot_vld   (slot_vld),
    .slot_idx   (slot_idx),
    .slot_phase (slot_phase),
    .sample_hit (sample_hit),
    .isa_sel    (isa_sel),
    .pci_sel    (pci_sel)
  );

  sirq_irq_latch #(.W(NUM_ISA)) u_isa (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (isa_sel),
    .line_in (line_in),
    .pull    (isa_pull)
  );

  sirq_irq_latch #(.W(NUM_PCI)) u_pci (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (pci_sel),
    .line_in (line_in),
    .pull    (pci_pull)
  );

  sirq_line_drive u_drive (
    .clk             (clk),
    .rst_n           (rst_n),
    .sample_hit      (sample_hit),
    .line_in         (line_in),
    .drive_hi        (drive_hi),
    .line_drive_high (line_drive_high)
  );

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (isa_pull == '0 && pci_pull == '0 && !line_drive_high));

  p_check_slot_dropped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_vld && slot_idx == IDX_W'(CHK_SLOT) && slot_phase == 2'd0)
      |=> $stable({isa_pull, pci_pull}));

  p_out_of_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_vld && slot_idx >= IDX_W'(NUM_SLOTS))
      |=> ($stable({isa_pull, pci_pull}) && !line_drive_high));

  p_non_sample_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_vld || slot_phase != 2'd0) |=> $stable({isa_pull, pci_pull}));

endmodule

// File: tb/test_sirq_frame_decoder.sv
module test_sirq_frame_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slot_vld = 1'b0;
  logic [4:0]  slot_idx = '0;
  logic [1:0]  slot_phase = 2'd0;
  logic        line_in = 1'b1;
  logic        drive_hi = 1'b0;
  logic [15:0] isa_pull;
  logic [3:0]  pci_pull;
  logic        line_drive_high;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_isa = '0;
  logic [3:0]  exp_pci = '0;

  always #2 clk = ~clk;

  sirq_frame_decoder i_sirq_frame_decoder (
    .clk             (clk),
    .rst_n           (rst_n),
    .slot_vld        (slot_vld),
    .slot_idx        (slot_idx),
    .slot_phase      (slot_phase),
    .line_in         (line_in),
    .drive_hi        (drive_hi),
    .isa_pull        (isa_pull),
    .pci_pull        (pci_pull),
    .line_drive_high (line_drive_high)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_outs(input string req);
    chk({isa_pull, pci_pull} === {exp_isa, exp_pci}, req,
        {12'd0, isa_pull, pci_pull}, {12'd0, exp_isa, exp_pci});
  endtask

  task automatic run_slot(input int idx, input bit v, input bit mode);
    string tag;
    @(negedge clk);
    slot_vld = 1'b1; slot_idx = idx[4:0]; slot_phase = 2'd0;
    line_in = v; drive_hi = mode;
    if (idx < 16) exp_isa[idx] = ~v;
    else if (idx > 16 && idx < 21) exp_pci[idx-17] = ~v;
    tag = (idx < 16) ? "R2" : ((idx == 16) ? "R4" : "R3");
    @(negedge clk);
    chk(line_drive_high === (mode & ~v), mode ? "R6" : "R7",
        {31'd0, line_drive_high}, {31'd0, mode & ~v});
    chk_outs(tag);
    slot_phase = 2'd1; line_in = ~v; drive_hi = ~mode;
    @(negedge clk);
    chk(line_drive_high === 1'b0, "R6", {31'd0, line_drive_high}, 32'd0);
    chk_outs("R5,R9");
    slot_phase = 2'd2; line_in = 1'b0;
  endtask

  task automatic stray(input bit vld, input logic [4:0] idx, input logic [1:0] ph, input string req);
    @(negedge clk);
    slot_vld = vld; slot_idx = idx; slot_phase = ph; line_in = 1'b0; drive_hi = 1'b1;
    @(negedge clk);
    chk_outs(req);
    chk(line_drive_high === 1'b0, req, {31'd0, line_drive_high}, 32'd0);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    // R1: strobe active with a low line while in reset
    slot_vld = 1'b1; slot_idx = 5'd3; slot_phase = 2'd0; line_in = 1'b0; drive_hi = 1'b1;
    repeat (3) @(negedge clk);
    chk_outs("R1");
    chk(line_drive_high === 1'b0, "R1", {31'd0, line_drive_high}, 32'd0);
    slot_vld = 1'b0; line_in = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_outs("R1");

    // every slot, both levels, both recovery modes
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 21; s++)
        for (int v = 0; v < 2; v++)
          run_slot(s, v[0], m[0]);
    // leave some outputs asserted before the stray checks
    run_slot(2, 1'b0, 1'b0);
    run_slot(18, 1'b0, 1'b0);

    // R8: out-of-range indices with the line low
    for (int k = 21; k < 32; k++) stray(1'b1, k[4:0], 2'd0, "R8");
    // R5: invalid strobes and phase code 3
    for (int k = 0; k < 21; k++) begin
      stray(1'b0, k[4:0], 2'd0, "R5");
      stray(1'b1, k[4:0], 2'd3, "R5");
    end

    // R9: pseudo-random full cycles
    lfsr = 32'hACE1_0F35;
    for (int c = 0; c < 40; c++) begin
      for (int s = 0; s < 21; s++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        run_slot(s, lfsr[0], c[0]);
      end
      @(negedge clk);
      chk_outs("R9");
    end

    // R4: the check slot cannot disturb a full pattern
    run_slot(16, 1'b0, 1'b1);
    run_slot(16, 1'b1, 1'b0);

    @(negedge clk);
    slot_vld = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule